// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This is the 8-bit arithmetic and logic unit of a small accumulator-style microcontroller core. The instruction decoder supplies an operation code, the destination bit of the instruction word, the working-register (accumulator) operand, the file-register or literal operand and the present status byte. The unit computes the result and the new carry, digit-carry and zero flags without any clock. It also returns a merged status byte in which only the flags that the operation owns are replaced.

A small registered stage holds a flag-write-enable mask and the matching flag values for one cycle. The status register can then commit them in the next phase of the instruction sequence. Instruction fetch, the register file and the sequencing state machine are outside the block.

Opcode encoding on `op_code`: 0 add, 1 subtract, 2 increment, 3 decrement, 4 AND, 5 inclusive OR, 6 XOR, 7 complement, 8 move-through, 9 rotate left, 10 rotate right, 11 nibble swap. Codes 12 to 15 are undefined. Status bit 0 is carry (C), bit 1 is digit carry (DC) and bit 2 is zero (Z). The mask bits use the same positions.

Top module: `acc_alu`

## Requirements
- R1: Add (code 0) gives result (f + w) mod 256. C is the carry out of bit 7 and DC is the carry out of bit 3. C, DC and Z are all updated.
- R2: Subtract (code 1) gives result (f - w) mod 256. C is 1 when f >= w (no borrow) and DC is 1 when f[3:0] >= w[3:0]. C, DC and Z are all updated.
- R3: Increment (code 2) and decrement (code 3) act on f and wrap modulo 256. Only Z is updated.
- R4: AND, inclusive OR and XOR (codes 4 to 6) combine w and f bitwise. Complement (code 7) gives ~f and move-through (code 8) gives f. These update only Z.
- R5: Rotate left (code 9) gives {f[6:0], C} with new C = f[7]. Rotate right (code 10) gives {C, f[7:1]} with new C = f[0]. Only C is updated, and DC and Z keep their old values.
- R6: Nibble swap (code 11) gives {f[3:0], f[7:4]} and leaves status unchanged.
- R7: Whenever Z is updated, it is 1 exactly when the 8-bit result is zero.
- R8: `wr_file` equals `dest_bit` (1 routes the result to the file register, 0 to the accumulator). The result value does not depend on `dest_bit`.
- R9: `status_next` equals `status_in` with only the updated flag bits replaced. Bits 7 to 3 always pass through unchanged.
- R10: One cycle after a cycle with `op_valid` high, `flag_we` holds that operation's mask (bit 0 C, bit 1 DC, bit 2 Z) and `flag_val` holds the new flag values ANDed with the mask. After a cycle with `op_valid` low, both are 0. Both are 0 during reset.
- R11: Undefined codes 12 to 15 give result f and update no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag-write stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Current operation is to be committed to status |
| op_code | input | 4 | Operation select |
| dest_bit | input | 1 | Destination bit of the instruction word |
| w_opnd | input | 8 | Accumulator operand |
| f_opnd | input | 8 | File-register or literal operand |
| status_in | input | 8 | Present status byte; bit 0 is the carry input |
| result | output | 8 | Combinational result |
| wr_file | output | 1 | Result goes to the file register (1) or the accumulator (0) |
| status_next | output | 8 | Status byte with the owned flags replaced |
| flag_we | output | 3 | Registered flag-write mask |
| flag_val | output | 3 | Registered masked flag values |

## Verification
Two functions can fall in the same cycle. The registered flag-write stage still presents the mask and values of operation N while the combinational path already shows the result and merged status of operation N+1. The bench provokes this overlap with long back-to-back runs of valid operations, with random opcodes, operands, carry inputs and gaps in `op_valid`. A behavioural model predicts the combinational outputs for the present operation and the registered outputs for the previous one, and the bench compares both on every clock. Directed cases cover carry and digit carry at the 0xFF and nibble boundaries, equal and smaller subtrahends, rotates through both carry values and the undefined codes.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_AND  = 4'd4,
    OP_IOR  = 4'd5,
    OP_XOR  = 4'd6,
    OP_COM  = 4'd7,
    OP_MOV  = 4'd8,
    OP_RLF  = 4'd9,
    OP_RRF  = 4'd10,
    OP_SWAP = 4'd11
  } alu_op_e;

  localparam int NFLAG  = 3;
  localparam int FL_C   = 0;
  localparam int FL_DC  = 1;
  localparam int FL_Z   = 2;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] f,
  input  logic [DW-1:0] w,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          dc_out
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] b_opnd;
  logic          cin;
  logic [DW:0]   full;
  logic [HALF:0] low;

  always_comb begin
    b_opnd = w;
    cin    = 1'b0;
    case (op)
      OP_ADD: begin b_opnd = w;       cin = 1'b0; end
      OP_SUB: begin b_opnd = ~w;      cin = 1'b1; end
      OP_INC: begin b_opnd = '0;      cin = 1'b1; end
      OP_DEC: begin b_opnd = '1;      cin = 1'b0; end
      default: begin b_opnd = w;      cin = 1'b0; end
    endcase
  end

  assign full   = {1'b0, f} + {1'b0, b_opnd} + {{DW{1'b0}}, cin};
  assign low    = {1'b0, f[HALF-1:0]} + {1'b0, b_opnd[HALF-1:0]} + {{HALF{1'b0}}, cin};
  assign sum    = full[DW-1:0];
  assign c_out  = full[DW];
  assign dc_out = low[HALF];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] f,
  input  logic [DW-1:0] w,
  output logic [DW-1:0] res
);
  localparam int HALF = DW / 2;

  always_comb begin
    case (op)
      OP_AND:  res = w & f;
      OP_IOR:  res = w | f;
      OP_XOR:  res = w ^ f;
      OP_COM:  res = ~f;
      OP_SWAP: res = {f[HALF-1:0], f[DW-1:HALF]};
      default: res = f;
    endcase
  end
endmodule

// File: rtl/acc_alu_rot.sv
module acc_alu_rot #(
  parameter int DW = 8
) (
  input  logic          to_left,
  input  logic [DW-1:0] f,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  always_comb begin
    if (to_left) begin
      res  = {f[DW-2:0], cin};
      cout = f[DW-1];
    end else begin
      res  = {cin, f[DW-1:1]};
      cout = f[0];
    end
  end
endmodule

// File: rtl/acc_alu_flagmask.sv
module acc_alu_flagmask
  import acc_alu_pkg::*;
(
  input  logic [3:0] op,
  output flag_vec_t  mask
);
  always_comb begin
    mask = '0;
    case (op)
      OP_ADD, OP_SUB: begin
        mask[FL_C]  = 1'b1;
        mask[FL_DC] = 1'b1;
        mask[FL_Z]  = 1'b1;
      end
      OP_INC, OP_DEC, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV:
        mask[FL_Z] = 1'b1;
      OP_RLF, OP_RRF:
        mask[FL_C] = 1'b1;
      default: mask = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic          dest_bit,
  input  logic [DW-1:0] w_opnd,
  input  logic [DW-1:0] f_opnd,
  input  logic [DW-1:0] status_in,
  output logic [DW-1:0] result,
  output logic          wr_file,
  output logic [DW-1:0] status_next,
  output logic [NFLAG-1:0] flag_we,
  output logic [NFLAG-1:0] flag_val
);
  logic [DW-1:0] ar_sum, lg_res, rt_res;
  logic          ar_c, ar_dc, rt_c;
  logic          is_arith, is_rot;
  flag_vec_t     mask, nf;
  flag_vec_t     we_d, val_d;
  logic          reg_en;

  acc_alu_arith #(.DW(DW)) u_arith (
    .op(op_code), .f(f_opnd), .w(w_opnd),
    .sum(ar_sum), .c_out(ar_c), .dc_out(ar_dc)
  );

  acc_alu_logic #(.DW(DW)) u_logic (
    .op(op_code), .f(f_opnd), .w(w_opnd), .res(lg_res)
  );

  acc_alu_rot #(.DW(DW)) u_rot (
    .to_left(op_code == OP_RLF), .f(f_opnd), .cin(status_in[FL_C]),
    .res(rt_res), .cout(rt_c)
  );

  acc_alu_flagmask u_mask (.op(op_code), .mask(mask));

  always_comb begin
    is_arith = (op_code == OP_ADD) || (op_code == OP_SUB) ||
               (op_code == OP_INC) || (op_code == OP_DEC);
    is_rot   = (op_code == OP_RLF) || (op_code == OP_RRF);
    if (is_arith)    result = ar_sum;
    else if (is_rot) result = rt_res;
    else             result = lg_res;
    nf[FL_C]  = is_rot ? rt_c : ar_c;
    nf[FL_DC] = ar_dc;
    nf[FL_Z]  = (result == '0);
  end

  assign wr_file = dest_bit;

  for (genvar b = 0; b < DW; b++) begin : g_status
    if (b < NFLAG) begin : g_flag
      assign status_next[b] = mask[b] ? nf[b] : status_in[b];
    end else begin : g_pass
      assign status_next[b] = status_in[b];
    end
  end

  always_comb begin
    reg_en = op_valid | (|flag_we);
    we_d   = op_valid ? mask : '0;
    val_d  = op_valid ? (nf & mask) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_we  <= '0;
      flag_val <= '0;
    end else if (reg_en) begin
      flag_we  <= we_d;
      flag_val <= val_d;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [3:0] op_code,
  input logic [7:0] f_opnd,
  input logic [7:0] status_in,
  input logic [7:0] result,
  input logic [7:0] status_next,
  input logic [2:0] flag_we,
  input logic [2:0] flag_val
);
  assert_swap_keeps_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_SWAP) |-> (status_next == status_in));

  assert_rot_keeps_dc_z_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_RLF || op_code == OP_RRF) |-> (status_next[2:1] == status_in[2:1]));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code <= OP_MOV) |-> (status_next[2] == (result == 8'h00)));

  assert_upper_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_next[7:3] == status_in[7:3]);

  assert_idle_clears_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (flag_we == 3'b000 && flag_val == 3'b000));

  assert_add_full_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ADD) |=> (flag_we == 3'b111));

  assert_undef_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > OP_SWAP) |-> (result == f_opnd && status_next == status_in));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .f_opnd(f_opnd), .status_in(status_in), .result(result),
  .status_next(status_next), .flag_we(flag_we), .flag_val(flag_val)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic       dest_bit;
  logic [7:0] w_opnd, f_opnd, status_in;
  logic [7:0] result, status_next;
  logic       wr_file;
  logic [2:0] flag_we, flag_val;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int exp_res, exp_st, exp_we, exp_val;
  int cur_op;

  always #(CLK_P/2) clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dest_bit(dest_bit), .w_opnd(w_opnd), .f_opnd(f_opnd),
    .status_in(status_in), .result(result), .wr_file(wr_file),
    .status_next(status_next), .flag_we(flag_we), .flag_val(flag_val)
  );

  function automatic string req_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5, 6, 7, 8: return "R4";
      9, 10: return "R5";
      11: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s op=%0d actual=%h expected=%h", req, cur_op, act, expv);
    end
  endtask

  task automatic apply(bit rn, bit v, int op, bit d, int w, int f, int st);
    int r, c, dc, z, m, nf, cin;
    rst_n = rn; op_valid = v; op_code = op[3:0]; dest_bit = d;
    w_opnd = w[7:0]; f_opnd = f[7:0]; status_in = st[7:0];
    cin = st & 1; c = 0; dc = 0; m = 0;
    case (op)
      0: begin r = (f + w) & 255; c = (f + w) > 255; dc = ((f & 15) + (w & 15)) > 15; m = 7; end
      1: begin r = (f - w) & 255; c = f >= w; dc = (f & 15) >= (w & 15); m = 7; end
      2: begin r = (f + 1) & 255; m = 4; end
      3: begin r = (f + 255) & 255; m = 4; end
      4: begin r = w & f; m = 4; end
      5: begin r = w | f; m = 4; end
      6: begin r = w ^ f; m = 4; end
      7: begin r = (~f) & 255; m = 4; end
      8: begin r = f; m = 4; end
      9: begin r = ((f << 1) | cin) & 255; c = (f >> 7) & 1; m = 1; end
      10: begin r = (f >> 1) | (cin << 7); c = f & 1; m = 1; end
      11: begin r = ((f & 15) << 4) | (f >> 4); m = 0; end
      default: begin r = f; m = 0; end
    endcase
    z = (r == 0);
    nf = c | (dc << 1) | (z << 2);
    exp_res = r;
    exp_st  = (st & ~m) | (nf & m);
    exp_we  = (rn && v) ? m : 0;
    exp_val = (rn && v) ? (nf & m) : 0;
    cur_op  = op;
  endtask

  task automatic tick();
    string rq;
    @(negedge clk);
    rq = req_of(cur_op);
    if (rst_n) begin
      chk(rq, result, exp_res);
      chk((cur_op <= 8) ? "R7" : "R9", status_next, exp_st);
      chk("R8", wr_file, dest_bit);
    end
    chk("R10", flag_we, exp_we);
    chk("R10", flag_val, exp_val);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int rop, st;
    apply(0, 1, 0, 0, 8'h12, 8'h34, 0);
    tick(); tick();
    // reset state of the flag stage, R10
    chk("R10", flag_we, 0);
    @(negedge clk);
    apply(1, 1, 0, 0, 8'hFF, 8'h01, 0);  tick();  // R1 wrap to zero, C DC Z set
    apply(1, 1, 0, 1, 8'h08, 8'h08, 8'hF8); tick(); // R1 DC only
    apply(1, 1, 1, 0, 8'h05, 8'h05, 0);  tick();  // R2 equal
    apply(1, 1, 1, 1, 8'h05, 8'h03, 7);  tick();  // R2 borrow
    apply(1, 1, 1, 0, 8'h01, 8'h10, 0);  tick();  // R2 nibble borrow only
    apply(1, 1, 2, 0, 0, 8'hFF, 0);      tick();  // R3 inc wrap
    apply(1, 1, 3, 1, 0, 8'h00, 3);      tick();  // R3 dec wrap
    apply(1, 1, 7, 0, 0, 8'hFF, 0);      tick();  // R4 complement to zero
    apply(1, 1, 9, 0, 0, 8'h80, 8'h04);  tick();  // R5 rotate left, Z kept
    apply(1, 1, 10, 1, 0, 8'h01, 8'h01); tick();  // R5 rotate right through C
    apply(1, 1, 11, 0, 0, 8'hA5, 8'hFF); tick();  // R6 swap
    apply(1, 0, 0, 0, 8'h01, 8'h01, 0);  tick();  // R10 idle clears stage
    for (int u = 12; u < 16; u++) begin
      apply(1, 1, u, u & 1, 8'h33, 8'h9C, 8'h55); tick(); // R11 undefined
    end
    for (int i = 0; i < 3000; i++) begin
      rop = $urandom_range(0, 15);
      st  = $urandom_range(0, 255);
      apply(1, ($urandom_range(0, 3) != 0), rop, $urandom_range(0, 1),
            $urandom_range(0, 255), $urandom_range(0, 255), st);
      tick();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule